// File: doc/BRIEF.md
# SPI Status Autopoll Engine

This block polls a device on an SPI link without software help. Software loads a command byte, picks one bit of the device's reply, states the value that bit must take, and starts the engine. The engine then runs tries on its own: each try selects the device, shifts out the command, shifts in one reply byte and deselects the device. It tests the chosen reply bit after every try and stops as soon as the bit has the wanted value, or when a budget of tries is used up.

The try budget is the 3-bit transfer clock code turned into a shift of the constant 31, plus a 4-bit timeout field from the poll register. A run ends in exactly one of two outcomes, success or timeout, and each outcome sets its own sticky status bit. Status bits are cleared by writing ones. A per-bit mask decides whether a newly set status bit raises the single interrupt pulse.

The serializer is a plain SPI mode-0 shifter: the clock idles low, MOSI changes while the clock is low and MISO is sampled on the rising clock edge, most significant bit first.

Top module: `spi_autopoll`

## Requirements
- R1: Each try drives `spi_cs_n` low, gives 16 rising edges of `spi_sck` (8 command bits on `spi_mosi`, MSB first, then 8 reply bits taken from `spi_miso`, MSB first), then drives `spi_cs_n` high before the next try. `spi_sck` is low whenever `spi_cs_n` is high.
- R2: The command sent on every try is poll register bits 7:0; the reply bit tested is the one selected by bits 26:24 (0 = LSB); the run succeeds on the first try whose tested bit equals bit 30.
- R3: The try budget is (31 << `clk_code`) + bits 19:16, with `clk_code` taken at the start write; a run with no matching reply performs exactly that many tries and then ends in timeout.
- R4: A write to the poll register with bit 31 set while idle starts a run; `ctl_rdata` bit 31 reads 1 while the run is active and 0 once it ends. A write with bit 31 clear while idle updates the fields without starting.
- R5: A poll register write while a run is active has no effect: fields and run behaviour are unchanged.
- R6: `irq_stat` bit 0 is set on success, bit 1 on timeout; exactly one of them is set per run, and a match on the last allowed try counts as success.
- R7: Writing `stat_wdata` with `stat_we` clears each `irq_stat` bit whose write bit is 1 and leaves the others.
- R8: `irq` pulses for one cycle when an `irq_stat` bit rises while its mask bit is 0; a mask bit of 1 (bit 0 success, bit 1 timeout) suppresses the pulse but not the status bit.
- R9: After reset the engine is idle, `ctl_rdata` is 0, `irq_stat` is 0, masks are 0, `spi_cs_n` is 1 and `spi_sck` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_code | input | 3 | Transfer clock code used for the try budget |
| cfg_we | input | 1 | Poll register write strobe |
| cfg_wdata | input | 32 | Poll register write data |
| ctl_rdata | output | 32 | Poll register readback (bit 31 = active) |
| mask_we | input | 1 | Interrupt mask write strobe |
| mask_wdata | input | 2 | Mask value (1 = disabled) |
| stat_we | input | 1 | Status clear strobe |
| stat_wdata | input | 2 | Write-one-to-clear bits |
| irq_stat | output | 2 | Status: bit 0 success, bit 1 timeout |
| irq | output | 1 | One-cycle interrupt pulse |
| spi_cs_n | output | 1 | Device select, active low |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Command data to device |
| spi_miso | input | 1 | Reply data from device |

## Verification
A table of runs varies the command byte, the tested bit position, the expected polarity, the clock code and the timeout field, with a device model that answers "no match" until a chosen try. Matches on the first try, in the middle, on exactly the last allowed try and one try beyond the budget separate the success-priority rule from an off-by-one in the budget, and two clock codes show that the shift enters the count. Reply bytes carry other bits set so that testing the wrong bit position or inverting the polarity changes the try count. Directed tests cover ignored writes during a run, field-only writes, masked interrupts and partial status clears.

// File: rtl/spi_ap_pkg.sv
// Package: shared widths, field positions and state types for the autopoll engine.
// Assumes: poll register layout fixed at 32 bits as described in the brief.
package spi_ap_pkg;

    localparam int CMD_W     = 8;
    localparam int SEL_W     = 3;
    localparam int TMO_W     = 4;
    localparam int CODE_W    = 3;
    localparam int BASE_TRY  = 31;
    // Enough bits for (31 << max code) + max timeout.
    localparam int TRY_W     = 5 + (1 << CODE_W) - 1 + 1;

    // Field positions in the poll register.
    localparam int POS_CMD   = 0;
    localparam int POS_TMO   = 16;
    localparam int POS_SEL   = 24;
    localparam int POS_POL   = 30;
    localparam int POS_GO    = 31;

    typedef struct packed {
        logic [CMD_W-1:0] cmd;
        logic [SEL_W-1:0] sel;
        logic [TMO_W-1:0] tmo;
        logic             pol;
    } poll_cfg_t;

    typedef enum logic [2:0] {
        SH_IDLE, SH_LEAD, SH_LOW, SH_HIGH, SH_TRAIL, SH_GAP
    } shift_state_t;

    typedef enum logic [1:0] {
        SQ_IDLE, SQ_ISSUE, SQ_WAIT
    } seq_state_t;

endpackage

// File: rtl/spi_ap_shifter.sv
// Module: one SPI mode-0 exchange per start pulse: select, shift out a
// command byte, shift in a reply byte, deselect, then a guard gap.
// Assumes: start is only pulsed while busy is low; HALF >= 1.
module spi_ap_shifter
    import spi_ap_pkg::*;
#(
    parameter int HALF = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CMD_W-1:0] tx_byte,
    output logic             busy,
    output logic             done,
    output logic [CMD_W-1:0] rx_byte,
    output logic             cs_n,
    output logic             sck,
    output logic             mosi,
    input  logic             miso
);
    localparam int DIV_W  = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int BITS   = 2 * CMD_W;
    localparam int IDX_W  = $clog2(BITS);

    shift_state_t     state;
    logic [DIV_W-1:0] div_cnt;
    logic [IDX_W-1:0] bit_idx;
    logic [CMD_W-1:0] tx_sr;
    logic [CMD_W-1:0] rx_sr;
    logic             tick;
    logic             in_cmd;

    assign tick    = (div_cnt == DIV_W'(HALF - 1));
    assign in_cmd  = (bit_idx < IDX_W'(CMD_W));
    assign busy    = (state != SH_IDLE);
    assign rx_byte = rx_sr;
    assign mosi    = ((state == SH_LOW) || (state == SH_HIGH)) && in_cmd && tx_sr[CMD_W-1];

    // Half-period divider, restarted at each exchange.
    always_ff @(posedge clk) begin
        if (!rst_n || state == SH_IDLE || tick) div_cnt <= '0;
        else                                   div_cnt <= div_cnt + 1'b1;
    end

    // Exchange sequencer: phases, shift registers and pin levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SH_IDLE;
            bit_idx <= '0;
            tx_sr   <= '0;
            rx_sr   <= '0;
            cs_n    <= 1'b1;
            sck     <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                SH_IDLE: begin
                    if (start) begin
                        tx_sr   <= tx_byte;
                        bit_idx <= '0;
                        cs_n    <= 1'b0;
                        state   <= SH_LEAD;
                    end
                end
                SH_LEAD: if (tick) state <= SH_LOW;
                SH_LOW: begin
                    if (tick) begin
                        sck <= 1'b1;
                        if (!in_cmd) rx_sr <= {rx_sr[CMD_W-2:0], miso};
                        state <= SH_HIGH;
                    end
                end
                SH_HIGH: begin
                    if (tick) begin
                        sck <= 1'b0;
                        if (bit_idx == IDX_W'(BITS - 1)) begin
                            state <= SH_TRAIL;
                        end else begin
                            if (in_cmd) tx_sr <= {tx_sr[CMD_W-2:0], 1'b0};
                            bit_idx <= bit_idx + 1'b1;
                            state   <= SH_LOW;
                        end
                    end
                end
                SH_TRAIL: begin
                    if (tick) begin
                        cs_n  <= 1'b1;
                        state <= SH_GAP;
                    end
                end
                SH_GAP: begin
                    if (tick) begin
                        done  <= 1'b1;
                        state <= SH_IDLE;
                    end
                end
                default: state <= SH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_ap_seq.sv
// Module: poll register, try budget, try counter and reply-bit compare.
// Emits one-cycle success or timeout events when a run ends.
// Assumes: the shifter reports done exactly once per start.
module spi_ap_seq
    import spi_ap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] clk_code,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       ctl_rdata,
    output logic              xfer_start,
    output logic [CMD_W-1:0]  xfer_cmd,
    input  logic              xfer_done,
    input  logic [CMD_W-1:0]  xfer_rx,
    output logic              ev_ok,
    output logic              ev_tmo
);
    seq_state_t       state;
    poll_cfg_t        cfg;
    logic [TRY_W-1:0] budget;
    logic [TRY_W-1:0] tries;
    logic             active;
    logic             hit;
    logic             last;
    logic             finish;

    assign active     = (state != SQ_IDLE);
    assign hit        = (xfer_rx[cfg.sel] == cfg.pol);
    assign last       = ((tries + 1'b1) == budget);
    assign finish     = (state == SQ_WAIT) && xfer_done;
    assign ev_ok      = finish && hit;
    assign ev_tmo     = finish && !hit && last;
    assign xfer_start = (state == SQ_ISSUE);
    assign xfer_cmd   = cfg.cmd;

    // Readback: fields at their fixed positions, bit 31 shows an active run.
    always_comb begin
        ctl_rdata                          = '0;
        ctl_rdata[POS_CMD +: CMD_W]        = cfg.cmd;
        ctl_rdata[POS_TMO +: TMO_W]        = cfg.tmo;
        ctl_rdata[POS_SEL +: SEL_W]        = cfg.sel;
        ctl_rdata[POS_POL]                 = cfg.pol;
        ctl_rdata[POS_GO]                  = active;
    end

    // Register write, run start and try loop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SQ_IDLE;
            cfg    <= '0;
            budget <= '0;
            tries  <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (cfg_we) begin
                        cfg.cmd <= cfg_wdata[POS_CMD +: CMD_W];
                        cfg.tmo <= cfg_wdata[POS_TMO +: TMO_W];
                        cfg.sel <= cfg_wdata[POS_SEL +: SEL_W];
                        cfg.pol <= cfg_wdata[POS_POL];
                        if (cfg_wdata[POS_GO]) begin
                            budget <= (TRY_W'(BASE_TRY) << clk_code)
                                    + TRY_W'(cfg_wdata[POS_TMO +: TMO_W]);
                            tries  <= '0;
                            state  <= SQ_ISSUE;
                        end
                    end
                end
                SQ_ISSUE: state <= SQ_WAIT;
                SQ_WAIT: begin
                    if (xfer_done) begin
                        tries <= tries + 1'b1;
                        if (hit || last) state <= SQ_IDLE;
                        else             state <= SQ_ISSUE;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_ap_irq.sv
// Module: sticky status bits, write-one-to-clear, mask and rising-edge pulse.
// Assumes: set events are single-cycle; a set wins over a clear in one cycle.
module spi_ap_irq #(
    parameter int NSRC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] ev_set,
    input  logic            stat_we,
    input  logic [NSRC-1:0] stat_wdata,
    input  logic            mask_we,
    input  logic [NSRC-1:0] mask_wdata,
    output logic [NSRC-1:0] stat,
    output logic            irq
);
    logic [NSRC-1:0] mask;
    logic [NSRC-1:0] stat_d;

    // Next status per source, built bit by bit.
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign stat_d[i] = ev_set[i] | (stat[i] & ~(stat_we & stat_wdata[i]));
    end

    // Status, mask and pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat <= '0;
            mask <= '0;
            irq  <= 1'b0;
        end else begin
            stat <= stat_d;
            if (mask_we) mask <= mask_wdata;
            irq  <= |(stat_d & ~stat & ~mask);
        end
    end
endmodule

// File: rtl/spi_autopoll.sv
// Module: top of the SPI status autopoll engine. Wires the poll sequencer,
// the byte shifter and the interrupt logic.
// Assumes: single clock domain; spi_miso is already synchronous to clk.
module spi_autopoll
    import spi_ap_pkg::*;
#(
    parameter int SCK_HALF = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  clk_code,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] ctl_rdata,
    input  logic        mask_we,
    input  logic [1:0]  mask_wdata,
    input  logic        stat_we,
    input  logic [1:0]  stat_wdata,
    output logic [1:0]  irq_stat,
    output logic        irq,
    output logic        spi_cs_n,
    output logic        spi_sck,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    logic             xfer_start;
    logic             xfer_done;
    logic             xfer_busy;
    logic [CMD_W-1:0] xfer_cmd;
    logic [CMD_W-1:0] xfer_rx;
    logic             ev_ok;
    logic             ev_tmo;

    spi_ap_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_code   (clk_code),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .ctl_rdata  (ctl_rdata),
        .xfer_start (xfer_start),
        .xfer_cmd   (xfer_cmd),
        .xfer_done  (xfer_done),
        .xfer_rx    (xfer_rx),
        .ev_ok      (ev_ok),
        .ev_tmo     (ev_tmo)
    );

    spi_ap_shifter #(.HALF(SCK_HALF)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (xfer_start),
        .tx_byte (xfer_cmd),
        .busy    (xfer_busy),
        .done    (xfer_done),
        .rx_byte (xfer_rx),
        .cs_n    (spi_cs_n),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .miso    (spi_miso)
    );

    spi_ap_irq #(.NSRC(2)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_set     ({ev_tmo, ev_ok}),
        .stat_we    (stat_we),
        .stat_wdata (stat_wdata),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .stat       (irq_stat),
        .irq        (irq)
    );
endmodule

// File: rtl/spi_autopoll_chk.sv
// Module: property checker for spi_autopoll, attached by bind.
// Assumes: observes top-level ports only.
module spi_autopoll_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [31:0] ctl_rdata,
    input logic [1:0]  irq_stat,
    input logic        irq,
    input logic        spi_cs_n,
    input logic        spi_sck
);
    // R1: device is never selected while no run is active.
    assert_idle_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rdata[31] |-> spi_cs_n);

    // R1: serial clock rests low while deselected.
    assert_sck_rest_R1: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    // R5: writes during a run leave the fields alone.
    assert_busy_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && ctl_rdata[31]) |=> $stable(ctl_rdata[30:0]));

    // R6: the end of a run leaves an outcome bit set.
    assert_end_has_outcome_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_rdata[31]) |-> (irq_stat != 2'b00));

    // R8: a pulse always has a status bit behind it.
    assert_irq_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($countones(irq_stat) >= 1));
endmodule

bind spi_autopoll spi_autopoll_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .ctl_rdata (ctl_rdata),
    .irq_stat  (irq_stat),
    .irq       (irq),
    .spi_cs_n  (spi_cs_n),
    .spi_sck   (spi_sck)
);

// File: tb/spi_autopoll_test.sv
// Bench: vector table of poll runs against a device model, then directed tests.
module spi_autopoll_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 6;
    localparam int WATCHDOG   = 190000;

    // code, tmo, cmd, sel, pol, pattern, match try (0 = never)
    typedef struct packed {
        logic [2:0]  code;
        logic [3:0]  tmo;
        logic [7:0]  cmd;
        logic [2:0]  sel;
        logic        pol;
        logic [7:0]  pat;
        logic [11:0] match_at;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 4'd0, 8'h05, 3'd0, 1'b1, 8'hA5, 12'd1},
        '{3'd0, 4'd3, 8'h9F, 3'd7, 1'b0, 8'h3C, 12'd5},
        '{3'd0, 4'd2, 8'hC3, 3'd3, 1'b1, 8'h00, 12'd0},
        '{3'd0, 4'd1, 8'h5A, 3'd5, 1'b0, 8'hFF, 12'd32},
        '{3'd1, 4'd0, 8'h81, 3'd2, 1'b1, 8'h69, 12'd63},
        '{3'd1, 4'd4, 8'h70, 3'd6, 1'b0, 8'h96, 12'd66}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  clk_code = '0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] ctl_rdata;
    logic        mask_we = 1'b0;
    logic [1:0]  mask_wdata = '0;
    logic        stat_we = 1'b0;
    logic [1:0]  stat_wdata = '0;
    logic [1:0]  irq_stat;
    logic        irq;
    logic        spi_cs_n;
    logic        spi_sck;
    logic        spi_mosi;
    logic        spi_miso;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int irq_cnt = 0;

    // Device model state.
    int         dev_bits = 0;
    int         dev_tries = 0;
    int         dev_badframe = 0;
    int         dev_badcmd = 0;
    logic [7:0] dev_cmd_in = '0;
    logic [7:0] exp_cmd = '0;
    logic [7:0] resp_hit = '0;
    logic [7:0] resp_miss = '0;
    int         match_at = 0;
    logic [7:0] cur_resp;

    spi_autopoll uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (irq) irq_cnt <= irq_cnt + 1;
    end

    // Device: reply matches from try number match_at (1-based) on.
    assign cur_resp = (match_at != 0 && dev_tries + 1 >= match_at) ? resp_hit : resp_miss;
    assign spi_miso = (dev_bits >= 8 && dev_bits < 16) ? cur_resp[15 - dev_bits] : 1'b0;

    always @(posedge spi_sck) begin
        if (dev_bits < 8) dev_cmd_in <= {dev_cmd_in[6:0], spi_mosi};
        dev_bits <= dev_bits + 1;
    end

    always @(posedge spi_cs_n) begin
        if (dev_bits != 16) dev_badframe <= dev_badframe + 1;
        if (dev_cmd_in != exp_cmd) dev_badcmd <= dev_badcmd + 1;
        dev_tries <= dev_tries + 1;
        dev_bits  <= 0;
    end

    task automatic check(input string req, input string what, input longint act, input longint exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic write_cfg(input logic [31:0] d);
        @(negedge clk);
        cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clear_stat(input logic [1:0] d);
        @(negedge clk);
        stat_wdata = d; stat_we = 1'b1;
        @(negedge clk);
        stat_we = 1'b0;
    endtask

    task automatic set_mask(input logic [1:0] d);
        @(negedge clk);
        mask_wdata = d; mask_we = 1'b1;
        @(negedge clk);
        mask_we = 1'b0;
    endtask

    task automatic wait_idle();
        while (ctl_rdata[31] && cycles < WATCHDOG) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [31:0] pack_cfg(input logic go, input logic pol, input logic [2:0] sel,
                                             input logic [3:0] tmo, input logic [7:0] cmd);
        pack_cfg = {go, pol, 3'b000, sel, 4'h0, tmo, 8'h00, cmd};
    endfunction

    task automatic prep_device(input logic [7:0] cmd, input logic [2:0] sel, input logic pol,
                               input logic [7:0] pat, input int m);
        logic [7:0] h;
        h = pat & ~(8'h01 << sel);
        if (pol) h = h | (8'h01 << sel);
        resp_hit  = h;
        resp_miss = h ^ (8'h01 << sel);
        exp_cmd   = cmd;
        match_at  = m;
        dev_tries = 0;
        dev_badframe = 0;
        dev_badcmd = 0;
        irq_cnt = 0;
    endtask

    initial begin
        // R9: reset state
        tick(3);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "ctl_rdata after reset", ctl_rdata, 0);
        check("R9", "irq_stat after reset", irq_stat, 0);
        check("R9", "cs_n after reset", spi_cs_n, 1);
        check("R9", "sck after reset", spi_sck, 0);
        check("R9", "irq after reset", irq, 0);

        // Vector table: R2, R3, R6, R1
        for (int i = 0; i < NVEC; i++) begin
            int budget;
            int exp_tries;
            logic [1:0] exp_stat;
            budget = (31 << VECS[i].code) + VECS[i].tmo;
            if (VECS[i].match_at != 0 && int'(VECS[i].match_at) <= budget) begin
                exp_tries = VECS[i].match_at;
                exp_stat  = 2'b01;
            end else begin
                exp_tries = budget;
                exp_stat  = 2'b10;
            end
            prep_device(VECS[i].cmd, VECS[i].sel, VECS[i].pol, VECS[i].pat, VECS[i].match_at);
            clk_code = VECS[i].code;
            write_cfg(pack_cfg(1'b1, VECS[i].pol, VECS[i].sel, VECS[i].tmo, VECS[i].cmd));
            check("R4", "active after start", ctl_rdata[31], 1);
            clk_code = ~VECS[i].code;   // R3: code is taken at start only
            wait_idle();
            check("R3", $sformatf("vec %0d try count", i), dev_tries, exp_tries);
            check("R6", $sformatf("vec %0d outcome", i), irq_stat, exp_stat);
            check("R2", $sformatf("vec %0d command errors", i), dev_badcmd, 0);
            check("R1", $sformatf("vec %0d frame errors", i), dev_badframe, 0);
            check("R8", $sformatf("vec %0d irq pulses", i), irq_cnt, 1);
            check("R4", $sformatf("vec %0d active cleared", i), ctl_rdata[31], 0);
            clear_stat(2'b11);
            check("R7", $sformatf("vec %0d clear", i), irq_stat, 0);
        end

        // R5: write while active is ignored
        clk_code = 3'd0;
        prep_device(8'h3A, 3'd1, 1'b1, 8'h00, 4);
        write_cfg(pack_cfg(1'b1, 1'b1, 3'd1, 4'd0, 8'h3A));
        tick(20);
        write_cfg(pack_cfg(1'b1, 1'b0, 3'd6, 4'd9, 8'hEE));
        check("R5", "fields during run", ctl_rdata, pack_cfg(1'b1, 1'b1, 3'd1, 4'd0, 8'h3A));
        wait_idle();
        check("R5", "tries after ignored write", dev_tries, 4);
        check("R5", "command after ignored write", dev_badcmd, 0);
        check("R6", "success after ignored write", irq_stat, 2'b01);

        // R7: partial clear keeps the other bit
        prep_device(8'h11, 3'd0, 1'b1, 8'h00, 0);
        write_cfg(pack_cfg(1'b1, 1'b1, 3'd0, 4'd0, 8'h11));
        wait_idle();
        check("R7", "both bits set", irq_stat, 2'b11);
        check("R8", "timeout pulse with success already set", irq_cnt, 1);
        clear_stat(2'b01);
        check("R7", "clear success only", irq_stat, 2'b10);
        clear_stat(2'b10);
        check("R7", "clear timeout", irq_stat, 2'b00);

        // R4: field-only write does not start
        write_cfg(pack_cfg(1'b0, 1'b1, 3'd2, 4'd5, 8'h42));
        tick(40);
        check("R4", "field write no start", ctl_rdata, pack_cfg(1'b0, 1'b1, 3'd2, 4'd5, 8'h42));
        check("R4", "field write keeps cs high", spi_cs_n, 1);

        // R8: masked success sets status, no pulse
        set_mask(2'b01);
        prep_device(8'h42, 3'd2, 1'b1, 8'h00, 2);
        write_cfg(pack_cfg(1'b1, 1'b1, 3'd2, 4'd5, 8'h42));
        wait_idle();
        check("R8", "masked success status", irq_stat, 2'b01);
        check("R8", "masked success pulses", irq_cnt, 0);
        clear_stat(2'b11);
        set_mask(2'b00);

        if (cycles >= WATCHDOG) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=<%0d", cycles, WATCHDOG);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: ends a hung run as a failure.
    initial begin
        #(CLK_PERIOD * (WATCHDOG + 5000));
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule